// File: doc/BRIEF.md
# Short-Vector Register Index Sequencer

This block turns a single vector-mode floating-point operation into a stream of per-element register index sets. A start pulse presents the first destination index, the first and second source indices, a precision flag, the vector length and stride fields of the floating-point control register, and two qualifiers. One qualifier marks an op with a single source. The other forces scalar execution, which the issuing logic raises for compare and conversion ops. The sequencer then emits one (destination, source 1, source 2) triple per accepted cycle over a valid/ready handshake. It computes no arithmetic and holds no register file.

The operating mode is chosen from the register banks of the operands. A destination in bank 0 makes the operation scalar. Otherwise a second source in bank 0 gives the mixed mode, in which that source is held fixed while the destination and first source step. With both in upper banks the mode is full vector. Every index steps by a precision-dependent amount and wraps inside its own bank, and its bank bits never change. Two read flags tell the datapath when a source must be fetched anew. When a single-source op holds its source fixed, the flags show that one computed result is written to each destination in turn.

Top module: `vreg_seq`

## Requirements
- R1: After reset, out_valid, done and busy are all 0.
- R2: A start while idle latches the inputs; the first element appears on the cycle after the start edge, with the start indices unchanged on out_dst, out_src1 and out_src2.
- R3: If the destination lies in bank 0 the operation is scalar: out_mode is 0 and exactly one element is emitted, whatever the length field. Bank 0 means index bits [4:3] are 00 in single precision and bits [3:2] are 00 in double precision.
- R4: When force_scalar is 1 exactly one element is emitted with out_mode 0, even for a destination in an upper bank.
- R5: In mixed or vector mode the number of elements emitted is vec_len + 1.
- R6: The destination step is stride + 1 in single precision (dbl=0) and (stride >> 1) + 1 in double precision (dbl=1).
- R7: An index advances by its step modulo the bank size (8 in single precision, low bits [2:0]; 4 in double precision, low bits [1:0]) with its bank bits held. In double precision index bit 4 is treated as 0.
- R8: A second source in bank 0 gives the mixed mode (out_mode 1) with out_src2 constant. Otherwise the mode is vector (out_mode 2) and out_src2 advances with the destination step.
- R9: out_src1 advances with the destination step on every element.
- R10: out_rd_src1 is 0 for single-source ops and 1 otherwise. out_rd_src2 is 1 on the first element and 1 on later elements only in vector mode. A single-source op with a held source therefore reuses one result for every destination.
- R11: An element stays unchanged while out_ready is 0; the next element is presented only after a cycle with out_valid and out_ready both 1.
- R12: done is 1 exactly in the cycle the last element is accepted, and busy and out_valid are 0 from the next cycle.
- R13: A start while busy is ignored, including a start in the same cycle as done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, taken only when idle |
| start_dst | input | 5 | First destination index |
| start_src1 | input | 5 | First index of source 1 |
| start_src2 | input | 5 | First index of source 2 (the bank-tested operand) |
| dbl | input | 1 | 1 = double-precision indices |
| one_src | input | 1 | 1 = op reads only source 2 |
| force_scalar | input | 1 | 1 = run as scalar regardless of length |
| vec_len | input | 3 | Element count minus one |
| stride | input | 2 | Stride field of the control register |
| out_ready | input | 1 | Consumer accepts the current element |
| out_valid | output | 1 | An element is presented |
| out_dst | output | 5 | Destination index of the element |
| out_src1 | output | 5 | Source 1 index of the element |
| out_src2 | output | 5 | Source 2 index of the element |
| out_rd_src1 | output | 1 | Source 1 must be read for this element |
| out_rd_src2 | output | 1 | Source 2 must be read for this element |
| out_mode | output | 2 | 0 scalar, 1 mixed, 2 vector |
| done | output | 1 | Last element accepted this cycle |
| busy | output | 1 | An operation is in progress |

## Verification
The two functions that can meet in one cycle are the completion of an operation and the arrival of a new start. The bench raises start in the very cycle that the final element is accepted with out_ready high. It checks that done is 1 in that cycle, and that on the following cycles busy and out_valid stay 0, so the start was dropped rather than latched. A second provocation raises start while the consumer stalls mid-sequence, and the bench checks that the presented element, its mode and the sequence continue unchanged.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

    localparam int IDX_W    = 5;
    localparam int LEN_W    = 3;
    localparam int STR_W    = 2;
    localparam int SP_LOW   = 3;
    localparam int DP_LOW   = 2;
    localparam int NUM_OPS  = 3;

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [LEN_W-1:0] len_t;
    typedef logic [STR_W-1:0] str_t;

    typedef enum logic [1:0] {
        MODE_SCALAR = 2'd0,
        MODE_MIXED  = 2'd1,
        MODE_VECTOR = 2'd2
    } mode_e;

    typedef struct packed {
        idx_t  dst;
        idx_t  s1;
        idx_t  s2;
        logic  dp;
        logic  one_src;
        logic  force_scalar;
        len_t  vec_len;
        str_t  stride;
    } req_t;

    typedef struct packed {
        idx_t  mask;
        idx_t  low;
        idx_t  step_d;
        idx_t  step_m;
        mode_e mode;
        logic  one_src;
    } cfg_t;

    typedef struct packed {
        cfg_t  cfg;
        idx_t  dst;
        idx_t  s1;
        idx_t  s2;
        len_t  last_n;
    } plan_t;

    function automatic idx_t low_bits(input logic dp);
        return dp ? idx_t'((1 << DP_LOW) - 1) : idx_t'((1 << SP_LOW) - 1);
    endfunction

    function automatic idx_t bank_bits(input logic dp);
        idx_t full_sp;
        idx_t full_dp;
        full_sp = idx_t'((1 << IDX_W) - 1);
        full_dp = idx_t'((1 << (IDX_W - 1)) - 1);
        return dp ? (full_dp ^ low_bits(1'b1)) : (full_sp ^ low_bits(1'b0));
    endfunction

    function automatic idx_t dest_step(input logic dp, input str_t stride);
        if (dp)
            return idx_t'(stride >> 1) + idx_t'(1);
        else
            return idx_t'(stride) + idx_t'(1);
    endfunction

    function automatic idx_t wrap_add(input idx_t idx, input idx_t step,
                                      input idx_t mask, input idx_t low);
        return ((idx + step) & low) | (idx & mask);
    endfunction

    function automatic idx_t fit_idx(input logic dp, input idx_t idx);
        return dp ? {1'b0, idx[IDX_W-2:0]} : idx;
    endfunction

endpackage

// File: rtl/vseq_decode.sv
module vseq_decode
    import vseq_pkg::*;
(
    input  req_t  req,
    output plan_t plan
);

    idx_t  mask;
    idx_t  dst_c;
    idx_t  s1_c;
    idx_t  s2_c;
    logic  dst_low_bank;
    logic  s2_low_bank;
    idx_t  step_d;

    always_comb begin
        mask         = bank_bits(req.dp);
        dst_c        = fit_idx(req.dp, req.dst);
        s1_c         = fit_idx(req.dp, req.s1);
        s2_c         = fit_idx(req.dp, req.s2);
        dst_low_bank = ((dst_c & mask) == '0);
        s2_low_bank  = ((s2_c & mask) == '0);
        step_d       = dest_step(req.dp, req.stride);

        plan.dst         = dst_c;
        plan.s1          = s1_c;
        plan.s2          = s2_c;
        plan.cfg.mask    = mask;
        plan.cfg.low     = low_bits(req.dp);
        plan.cfg.one_src = req.one_src;
        plan.cfg.step_d  = step_d;

        if (req.force_scalar || dst_low_bank) begin
            plan.cfg.mode   = MODE_SCALAR;
            plan.cfg.step_m = '0;
            plan.last_n     = '0;
        end else if (s2_low_bank) begin
            plan.cfg.mode   = MODE_MIXED;
            plan.cfg.step_m = '0;
            plan.last_n     = req.vec_len;
        end else begin
            plan.cfg.mode   = MODE_VECTOR;
            plan.cfg.step_m = step_d;
            plan.last_n     = req.vec_len;
        end
    end

endmodule

// File: rtl/vseq_idx_reg.sv
module vseq_idx_reg
    import vseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  idx_t load_val,
    input  logic adv,
    input  idx_t step,
    input  idx_t mask,
    input  idx_t low,
    output idx_t q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (adv)
            q <= wrap_add(q, step, mask, low);
    end

    // R7: bank bits survive every advance
    a_r7_bank_held: assert property (@(posedge clk) disable iff (rst)
        adv && !load |=> ((q & mask) == ($past(q) & mask)));

    // R8: a zero step keeps the index in place
    a_r8_zero_step_holds: assert property (@(posedge clk) disable iff (rst)
        adv && !load && (step == '0) |=> $stable(q));

endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
    import vseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  len_t last_n,
    input  logic out_ready,
    output logic accept,
    output logic busy,
    output logic first,
    output logic adv,
    output logic done
);

    len_t remain;
    logic fire;
    logic at_last;

    always_comb begin
        accept  = start && !busy;
        fire    = busy && out_ready;
        at_last = (remain == '0);
        done    = fire && at_last;
        adv     = fire && !at_last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
            first  <= 1'b0;
        end else if (accept) begin
            busy   <= 1'b1;
            remain <= last_n;
            first  <= 1'b1;
        end else if (fire) begin
            if (at_last) begin
                busy  <= 1'b0;
                first <= 1'b0;
            end else begin
                remain <= remain - len_t'(1);
                first  <= 1'b0;
            end
        end
    end

    // R12: completion leaves the unit idle on the next cycle
    a_r12_idle_after_done: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R11: a stalled element does not move on
    a_r11_stall_holds: assert property (@(posedge clk) disable iff (rst)
        busy && !out_ready |=> busy && $stable(remain) && $stable(first));

    // R13: a start during an operation does not reload the count
    a_r13_start_ignored: assert property (@(posedge clk) disable iff (rst)
        busy && start && !out_ready |=> $stable(remain));

    // R12: done only ever accompanies an accepted element
    a_r12_done_on_fire: assert property (@(posedge clk) disable iff (rst)
        done |-> busy && out_ready);

endmodule

// File: rtl/vreg_seq.sv
module vreg_seq
    import vseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [4:0] start_dst,
    input  logic [4:0] start_src1,
    input  logic [4:0] start_src2,
    input  logic       dbl,
    input  logic       one_src,
    input  logic       force_scalar,
    input  logic [2:0] vec_len,
    input  logic [1:0] stride,
    input  logic       out_ready,
    output logic       out_valid,
    output logic [4:0] out_dst,
    output logic [4:0] out_src1,
    output logic [4:0] out_src2,
    output logic       out_rd_src1,
    output logic       out_rd_src2,
    output logic [1:0] out_mode,
    output logic       done,
    output logic       busy
);

    req_t  req;
    plan_t plan;
    cfg_t  cfg_q;
    logic  accept;
    logic  first;
    logic  adv;
    idx_t  ld_val [NUM_OPS];
    idx_t  steps  [NUM_OPS];
    idx_t  cur    [NUM_OPS];

    always_comb begin
        req.dst          = start_dst;
        req.s1           = start_src1;
        req.s2           = start_src2;
        req.dp           = dbl;
        req.one_src      = one_src;
        req.force_scalar = force_scalar;
        req.vec_len      = vec_len;
        req.stride       = stride;
    end

    vseq_decode u_decode (
        .req  (req),
        .plan (plan)
    );

    vseq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .last_n    (plan.last_n),
        .out_ready (out_ready),
        .accept    (accept),
        .busy      (busy),
        .first     (first),
        .adv       (adv),
        .done      (done)
    );

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (accept)
            cfg_q <= plan.cfg;
    end

    assign ld_val = '{plan.dst, plan.s1, plan.s2};
    assign steps  = '{cfg_q.step_d, cfg_q.step_d, cfg_q.step_m};

    generate
        for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
            vseq_idx_reg u_reg (
                .clk      (clk),
                .rst      (rst),
                .load     (accept),
                .load_val (ld_val[g]),
                .adv      (adv),
                .step     (steps[g]),
                .mask     (cfg_q.mask),
                .low      (cfg_q.low),
                .q        (cur[g])
            );
        end
    endgenerate

    always_comb begin
        out_valid   = busy;
        out_dst     = cur[0];
        out_src1    = cur[1];
        out_src2    = cur[2];
        out_mode    = cfg_q.mode;
        out_rd_src1 = busy && !cfg_q.one_src;
        out_rd_src2 = busy && (first || (cfg_q.mode == MODE_VECTOR));
    end

    // R3: a scalar operation completes on its only element
    a_r3_scalar_one_element: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && (out_mode == MODE_SCALAR) |-> done);

    // R10: single-source ops never request source 1
    a_r10_no_src1_read: assert property (@(posedge clk) disable iff (rst)
        out_valid && cfg_q.one_src |-> !out_rd_src1);

    // R8: in mixed mode source 2 stays put across an accepted element
    a_r8_mixed_src2_fixed: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && !done && (out_mode == MODE_MIXED) |=> $stable(out_src2));

    // R11: a stalled element is held on the outputs
    a_r11_outputs_held: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_dst) && $stable(out_src1)
                                    && $stable(out_src2) && $stable(out_mode));

endmodule

// File: tb/vreg_seq_bench.sv
`timescale 1ns/100ps
module vreg_seq_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic [4:0] start_dst, start_src1, start_src2;
    logic       dbl, one_src, force_scalar;
    logic [2:0] vec_len;
    logic [1:0] stride;
    logic       out_ready;
    logic       out_valid;
    logic [4:0] out_dst, out_src1, out_src2;
    logic       out_rd_src1, out_rd_src2;
    logic [1:0] out_mode;
    logic       done, busy;

    int checks = 0;
    int errors = 0;
    logic [4:0] obs_dst [16];
    logic [4:0] obs_s1  [16];
    logic [4:0] obs_s2  [16];

    always #2.5 clk = ~clk;

    vreg_seq u_vreg_seq (
        .clk, .rst, .start, .start_dst, .start_src1, .start_src2,
        .dbl, .one_src, .force_scalar, .vec_len, .stride, .out_ready,
        .out_valid, .out_dst, .out_src1, .out_src2, .out_rd_src1,
        .out_rd_src2, .out_mode, .done, .busy
    );

    task automatic chk(input logic ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL [R11] watchdog expired actual=hung expected=finished");
        finish_run();
    end

    task automatic drive_start(input logic dp, os, fs, input logic [2:0] vl,
                               input logic [1:0] st, input logic [4:0] d, a, b);
        dbl = dp; one_src = os; force_scalar = fs; vec_len = vl; stride = st;
        start_dst = d; start_src1 = a; start_src2 = b; start = 1'b1;
    endtask

    // generic run: expected sequence derived from the requirement rules
    task automatic run_seq(input string tag, input logic dp, os, fs,
                           input logic [2:0] vl, input logic [1:0] st,
                           input logic [4:0] d, a, b, input logic [15:0] rpat);
        logic [4:0] mask, low, sd, sm, ed, ea, eb;
        int n, mode, k, cyc;
        mask = dp ? 5'h0C : 5'h18;
        low  = dp ? 5'h03 : 5'h07;
        sd   = dp ? 5'(st >> 1) + 5'd1 : 5'(st) + 5'd1;
        if (fs || ((d & mask) == 0)) begin mode = 0; n = 1; sm = 0; end
        else if ((b & mask) == 0) begin mode = 1; n = vl + 1; sm = 0; end
        else begin mode = 2; n = vl + 1; sm = sd; end
        ed = d; ea = a; eb = b;
        @(negedge clk);
        drive_start(dp, os, fs, vl, st, d, a, b);
        out_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        k = 0; cyc = 0;
        while (k < n && cyc < 64) begin
            chk(out_valid == 1'b1, {tag, " [R2] valid"}, out_valid, 1);
            chk(out_dst == ed,  {tag, " [R6] dst"},  out_dst,  ed);
            chk(out_src1 == ea, {tag, " [R9] src1"}, out_src1, ea);
            chk(out_src2 == eb, {tag, " [R8] src2"}, out_src2, eb);
            chk(out_mode == 2'(mode), {tag, " [R3] mode"}, out_mode, mode);
            chk(out_rd_src1 == !os, {tag, " [R10] rd_src1"}, out_rd_src1, !os);
            chk(out_rd_src2 == (k == 0 || mode == 2), {tag, " [R10] rd_src2"},
                out_rd_src2, (k == 0 || mode == 2));
            out_ready = rpat[cyc % 16];
            #1;
            chk(done == (out_ready && k == n - 1), {tag, " [R12] done"},
                done, (out_ready && k == n - 1));
            if (out_ready) begin
                obs_dst[k] = out_dst; obs_s1[k] = out_src1; obs_s2[k] = out_src2;
                ed = ((ed + sd) & low) | (ed & mask);
                ea = ((ea + sd) & low) | (ea & mask);
                eb = ((eb + sm) & low) | (eb & mask);
                k++;
            end
            cyc++;
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk(busy == 1'b0 && out_valid == 1'b0, {tag, " [R5] idle after count"}, busy, 0);
    endtask

    task automatic test_reset();
        rst = 1'b1; start = 1'b0; out_ready = 1'b0;
        drive_start(0, 0, 0, 0, 0, 0, 0, 0); start = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        chk(out_valid == 0, "[R1] reset out_valid", out_valid, 0);
        chk(done == 0, "[R1] reset done", done, 0);
        chk(busy == 0, "[R1] reset busy", busy, 0);
    endtask

    task automatic test_scalar_dest();
        run_seq("r3_scalar", 0, 0, 0, 3'd5, 2'd0, 5'd5, 5'd17, 5'd26, 16'hFFFF);
        run_seq("r3_scalar_dp", 1, 0, 0, 3'd3, 2'd0, 5'd2, 5'd9, 5'd13, 16'hFFFF);
    endtask

    task automatic test_force_scalar();
        run_seq("r4_force", 0, 0, 1, 3'd3, 2'd0, 5'd9, 5'd17, 5'd25, 16'hFFFF);
    endtask

    task automatic test_vector();
        run_seq("r5_vector", 0, 0, 0, 3'd3, 2'd0, 5'd8, 5'd16, 5'd24, 16'hFFFF);
        run_seq("r5_full", 0, 0, 0, 3'd7, 2'd3, 5'd26, 5'd10, 5'd19, 16'hFFFF);
    endtask

    task automatic test_wrap();
        logic [4:0] xd [4];
        logic [4:0] x1 [4];
        logic [4:0] x2 [4];
        xd = '{5'd13, 5'd15, 5'd9,  5'd11};
        x1 = '{5'd21, 5'd23, 5'd17, 5'd19};
        x2 = '{5'd30, 5'd24, 5'd26, 5'd28};
        run_seq("r7_wrap_sp", 0, 0, 0, 3'd3, 2'd1, 5'd13, 5'd21, 5'd30, 16'hFFFF);
        for (int i = 0; i < 4; i++) begin
            chk(obs_dst[i] == xd[i], "[R7] sp dst wrap", obs_dst[i], xd[i]);
            chk(obs_s1[i] == x1[i], "[R7] sp src1 wrap", obs_s1[i], x1[i]);
            chk(obs_s2[i] == x2[i], "[R7] sp src2 wrap", obs_s2[i], x2[i]);
        end
    endtask

    task automatic test_double();
        logic [4:0] xd [3];
        logic [4:0] x2 [3];
        xd = '{5'd6, 5'd4, 5'd6};
        x2 = '{5'd13, 5'd15, 5'd13};
        run_seq("r6_dp", 1, 0, 0, 3'd2, 2'd3, 5'd6, 5'd10, 5'd13, 16'hFFFF);
        for (int i = 0; i < 3; i++) begin
            chk(obs_dst[i] == xd[i], "[R6] dp dst step", obs_dst[i], xd[i]);
            chk(obs_s2[i] == x2[i], "[R7] dp src2 wrap", obs_s2[i], x2[i]);
        end
    endtask

    task automatic test_mixed();
        run_seq("r8_mixed", 0, 0, 0, 3'd2, 2'd0, 5'd8, 5'd16, 5'd2, 16'hFFFF);
        for (int i = 0; i < 3; i++)
            chk(obs_s2[i] == 5'd2, "[R8] mixed src2 fixed", obs_s2[i], 2);
    endtask

    task automatic test_one_src_reuse();
        run_seq("r10_reuse", 0, 1, 0, 3'd3, 2'd0, 5'd16, 5'd0, 5'd1, 16'hFFFF);
        run_seq("r10_onesrc_vec", 0, 1, 0, 3'd2, 2'd1, 5'd16, 5'd0, 5'd9, 16'hFFFF);
    endtask

    task automatic test_stall();
        run_seq("r11_stall", 0, 0, 0, 3'd4, 2'd0, 5'd12, 5'd20, 5'd28, 16'b0101_1001_0011_0110);
    endtask

    task automatic test_ignore_start();
        @(negedge clk);
        drive_start(0, 0, 0, 3'd2, 2'd0, 5'd8, 5'd16, 5'd24);
        out_ready = 1'b0;
        @(negedge clk);
        drive_start(0, 0, 1, 3'd0, 2'd3, 5'd17, 5'd3, 5'd4);
        @(negedge clk);
        start = 1'b0;
        chk(out_dst == 5'd8, "[R13] busy start ignored dst", out_dst, 8);
        chk(out_mode == 2'd2, "[R13] busy start ignored mode", out_mode, 2);
        out_ready = 1'b1;
        @(negedge clk);
        chk(out_dst == 5'd9, "[R13] sequence continues", out_dst, 9);
        @(negedge clk);
        chk(out_dst == 5'd10, "[R13] last element", out_dst, 10);
        drive_start(0, 0, 0, 3'd1, 2'd0, 5'd8, 5'd8, 5'd8);
        #1;
        chk(done == 1'b1, "[R12] done with last element", done, 1);
        @(negedge clk);
        start = 1'b0; out_ready = 1'b0;
        chk(busy == 1'b0, "[R13] start in done cycle ignored", busy, 0);
        chk(out_valid == 1'b0, "[R12] valid drops after done", out_valid, 0);
        @(negedge clk);
        chk(busy == 1'b0, "[R13] still idle", busy, 0);
    endtask

    initial begin
        test_reset();
        test_scalar_dest();
        test_force_scalar();
        test_vector();
        test_wrap();
        test_double();
        test_mixed();
        test_one_src_reuse();
        test_stall();
        test_ignore_start();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule